// File: doc/BRIEF.md
# Compare-and-store conditional handler

This unit sits on the memory side of a shared cache and serves requests from a set of private caches. A store-conditional packet carries two values: the value the requester read at its earlier linked load, and the value it now wants to store. The unit reads the current word, or the current pair of words for a 64-bit access, from its data array and compares it with the carried value. The write is committed only when the two are equal, so success depends on the data being unchanged. No per-requester reservation is held here.

When a conditional store commits, every registered sharer of the line gets a coherence message. The requester answers TRUE only after all of those messages are acknowledged. A plain write uses the same sharer path but skips its own source. A cachable read returns the whole line and records the reader as a sharer. If the line is not present, the request is passed unchanged to an external-memory transaction port.

Requests arrive as a flit stream with valid/ready. The header fields stay constant for the whole packet. Responses, coherence messages and external-memory records leave on valid/ready streams. A producer may hold valid for as long as ready is low, and every payload field stays stable until the cycle in which valid and ready are both high. Acknowledgements and the miss indication are plain pins.

Top module: `cas_commit_unit`

## Requirements
- R1: A 32-bit conditional store (req_op=2, req_long=0) has two flits, the expected old word and then the new word. When the old word equals the stored word, the new word is written and the response has rsp_kind=2 and rsp_data=1.
- R2: When a conditional store's old value differs from the stored value, nothing is written, no coherence message is sent, and the response has rsp_kind=2 and rsp_data=0.
- R3: A 64-bit conditional store (req_long=1) has four flits in this order: old low word, old high word, new low word, new high word. It addresses the even/odd word pair that contains req_addr, and it succeeds only if both halves match.
- R4: A committed conditional store sends one update message (coh_kind=0) to every sharer of the line, the requester included. Each message carries the new value in coh_data, with the low word in the low bits.
- R5: The response to a request that sent coherence messages is not presented until one coh_ack pulse has been received for every message sent.
- R6: A plain write (req_op=1; one flit, or two flits low then high when req_long=1) stores the data and sends an update to every sharer of the line except req_src. The response has rsp_kind=1 and comes only after all acknowledgements.
- R7: A read (req_op=0, one flit whose data is ignored) with req_cach=1 returns the LINE_WORDS words of its line, from the line base upward, and records req_src as a sharer. With req_cach=0 it returns one word and records nothing. Read flits have rsp_kind=0, and rsp_last is high only on the final flit.
- R8: If line_miss is high when a packet is decided, the packet is emitted once on the xram port (op, source, address, width, old pair, new pair). Nothing is written locally and no response is produced.
- R9: req_ready is low from the moment a packet completes until its response, or its external record, has been handed off.
- R10: Under back-pressure, rsp_valid, coh_valid and xram_valid stay high with stable payload until the cycle in which they are accepted.
- R11: After reset, req_ready is high, all output valids are low, every data word reads as zero and no line has sharers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request flit valid |
| req_ready | output | 1 | Request flit accepted when high with valid |
| req_data | input | W | Flit payload word |
| req_op | input | 2 | 0 read, 1 write, 2 conditional store |
| req_src | input | SW | Requesting cache index |
| req_addr | input | AW | Word address |
| req_long | input | 1 | 64-bit access |
| req_cach | input | 1 | Cachable read |
| line_miss | input | 1 | Line not present in the data array |
| rsp_valid | output | 1 | Response flit valid |
| rsp_ready | input | 1 | Response flit taken |
| rsp_src | output | SW | Destination cache of the response |
| rsp_kind | output | 2 | 0 read data, 1 write done, 2 conditional result |
| rsp_data | output | W | Read word or result (1 true, 0 false) |
| rsp_last | output | 1 | Final flit of the response |
| coh_valid | output | 1 | Coherence message valid |
| coh_ready | input | 1 | Coherence message taken |
| coh_dst | output | SW | Target sharer |
| coh_kind | output | 1 | 0 update, 1 invalidate |
| coh_addr | output | AW | Address written |
| coh_long | output | 1 | 64-bit data |
| coh_data | output | 2*W | New value, low word in low bits |
| coh_ack | input | 1 | One acknowledgement per pulse |
| xram_valid | output | 1 | External transaction record valid |
| xram_ready | input | 1 | Record taken |
| xram_op | output | 2 | Operation of the record |
| xram_src | output | SW | Source of the record |
| xram_addr | output | AW | Address of the record |
| xram_long | output | 1 | Width of the record |
| xram_old | output | 2*W | Expected old value |
| xram_new | output | 2*W | Value to store |

## Verification
A wrong comparison or a write to the wrong half shows up at once in the conditional result. A plain single-word read right after the request then reveals the corrupted or missing store. If the sharer state is wrong, the set of coh_dst targets differs from the expected set within a few cycles of the commit. If the acknowledgement counter is wrong, the response appears before the final coh_ack, or never appears at all. The bench probes for both of these by checking rsp_valid between the individual acknowledgement pulses. Handshake faults are visible as payload that changes while ready is held low, or as req_ready rising while a packet is still in flight.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_SC = 2'd2, OP_RSVD = 2'd3} op_e;
  typedef enum logic [1:0] {RK_DATA = 2'd0, RK_WACK = 2'd1, RK_SC = 2'd2, RK_RSVD = 2'd3} rkind_e;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_COH = 2'd1, S_RSP = 2'd2, S_XRAM = 2'd3} state_e;
  localparam logic CK_UPDATE = 1'b0;
  localparam logic CK_INVAL  = 1'b1;
  localparam int   MAX_FLITS = 4;

  function automatic logic [2:0] flits_for(logic [1:0] op, logic lng);
    case (op)
      OP_SC:    return lng ? 3'd4 : 3'd2;
      OP_WRITE: return lng ? 3'd2 : 3'd1;
      default:  return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/cas_pkt_collect.sv
module cas_pkt_collect
  import cas_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 4,
  parameter int SW = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           accept_en,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [W-1:0]                   in_data,
  input  logic [1:0]                     in_op,
  input  logic [SW-1:0]                  in_src,
  input  logic [AW-1:0]                  in_addr,
  input  logic                           in_long,
  input  logic                           in_cach,
  output logic                           pkt_valid,
  input  logic                           pkt_take,
  output logic [1:0]                     pkt_op,
  output logic [SW-1:0]                  pkt_src,
  output logic [AW-1:0]                  pkt_addr,
  output logic                           pkt_long,
  output logic                           pkt_cach,
  output logic [MAX_FLITS-1:0][W-1:0]    pkt_words
);
  logic [1:0] cnt_q;
  logic       fire;
  logic [1:0] hdr_op;
  logic       hdr_long;
  logic [2:0] need;

  assign in_ready = accept_en && !pkt_valid;
  assign fire     = in_valid && in_ready;
  assign hdr_op   = (cnt_q == 2'd0) ? in_op : pkt_op;
  assign hdr_long = (cnt_q == 2'd0) ? in_long : pkt_long;
  assign need     = flits_for(hdr_op, hdr_long);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pkt_valid <= 1'b0;
      pkt_op    <= '0;
      pkt_src   <= '0;
      pkt_addr  <= '0;
      pkt_long  <= 1'b0;
      pkt_cach  <= 1'b0;
      pkt_words <= '0;
    end else begin
      if (pkt_take) pkt_valid <= 1'b0;
      if (fire) begin
        if (cnt_q == 2'd0) begin
          pkt_op    <= in_op;
          pkt_src   <= in_src;
          pkt_addr  <= in_addr;
          pkt_long  <= in_long;
          pkt_cach  <= in_cach;
          pkt_words <= '0;
        end
        pkt_words[cnt_q] <= in_data;
        if ({1'b0, cnt_q} + 3'd1 == need) begin
          cnt_q     <= '0;
          pkt_valid <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/cas_store.sv
module cas_store #(
  parameter int W          = 32,
  parameter int NWORDS     = 16,
  parameter int LINE_WORDS = 4,
  parameter int NSRC       = 4,
  localparam int AW        = $clog2(NWORDS),
  localparam int LW        = $clog2(LINE_WORDS),
  localparam int SW        = $clog2(NSRC),
  localparam int NLINES    = NWORDS / LINE_WORDS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   pa_addr,
  input  logic            pa_long,
  output logic [W-1:0]    pa_lo,
  output logic [W-1:0]    pa_hi,
  input  logic [AW-1:0]   wd_addr,
  output logic [W-1:0]    wd_data,
  input  logic            wr_en,
  input  logic            wr_long,
  input  logic [AW-1:0]   wr_addr,
  input  logic [W-1:0]    wr_lo,
  input  logic [W-1:0]    wr_hi,
  input  logic [AW-1:0]   dir_addr,
  output logic [NSRC-1:0] dir_mask,
  input  logic            dir_set_en,
  input  logic [SW-1:0]   dir_set_src,
  input  logic            dir_clr_en
);
  logic [W-1:0]    mem [NWORDS];
  logic [NSRC-1:0] dir [NLINES];
  logic [AW-1:0]   a_lo, a_hi, w_lo, w_hi;

  assign a_lo     = pa_long ? {pa_addr[AW-1:1], 1'b0} : pa_addr;
  assign a_hi     = {pa_addr[AW-1:1], 1'b1};
  assign pa_lo    = mem[a_lo];
  assign pa_hi    = mem[a_hi];
  assign wd_data  = mem[wd_addr];
  assign dir_mask = dir[dir_addr[AW-1:LW]];
  assign w_lo     = wr_long ? {wr_addr[AW-1:1], 1'b0} : wr_addr;
  assign w_hi     = {wr_addr[AW-1:1], 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
      for (int j = 0; j < NLINES; j++) dir[j] <= '0;
    end else begin
      if (wr_en) begin
        mem[w_lo] <= wr_lo;
        if (wr_long) mem[w_hi] <= wr_hi;
      end
      if (dir_clr_en)      dir[dir_addr[AW-1:LW]] <= '0;
      else if (dir_set_en) dir[dir_addr[AW-1:LW]][dir_set_src] <= 1'b1;
    end
  end
endmodule

// File: rtl/cas_coh_seq.sv
module cas_coh_seq #(
  parameter int W    = 32,
  parameter int AW   = 4,
  parameter int NSRC = 4,
  localparam int SW  = $clog2(NSRC),
  localparam int CW  = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NSRC-1:0] start_mask,
  input  logic            start_kind,
  input  logic [AW-1:0]   start_addr,
  input  logic            start_long,
  input  logic [2*W-1:0]  start_data,
  output logic            coh_valid,
  input  logic            coh_ready,
  output logic [SW-1:0]   coh_dst,
  output logic            coh_kind,
  output logic [AW-1:0]   coh_addr,
  output logic            coh_long,
  output logic [2*W-1:0]  coh_data,
  input  logic            coh_ack,
  output logic            done
);
  logic [NSRC-1:0] pend_q;
  logic [CW-1:0]   cnt_q;

  function automatic logic [CW-1:0] popcnt(logic [NSRC-1:0] m);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < NSRC; i++) n = n + CW'(m[i]);
    return n;
  endfunction

  always_comb begin
    coh_dst = '0;
    for (int i = NSRC - 1; i >= 0; i--) if (pend_q[i]) coh_dst = SW'(i);
  end

  assign coh_valid = |pend_q;
  assign done      = (pend_q == '0) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      cnt_q    <= '0;
      coh_kind <= 1'b0;
      coh_addr <= '0;
      coh_long <= 1'b0;
      coh_data <= '0;
    end else if (start) begin
      pend_q   <= start_mask;
      cnt_q    <= popcnt(start_mask);
      coh_kind <= start_kind;
      coh_addr <= start_addr;
      coh_long <= start_long;
      coh_data <= start_data;
    end else begin
      if (coh_valid && coh_ready) pend_q[coh_dst] <= 1'b0;
      if (coh_ack && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/cas_commit_unit.sv
module cas_commit_unit
  import cas_pkg::*;
#(
  parameter int W           = 32,
  parameter int NWORDS      = 16,
  parameter int LINE_WORDS  = 4,
  parameter int NSRC        = 4,
  parameter bit INVAL_ON_SC = 1'b0,
  localparam int AW         = $clog2(NWORDS),
  localparam int LW         = $clog2(LINE_WORDS),
  localparam int SW         = $clog2(NSRC),
  localparam int RW         = $clog2(LINE_WORDS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [W-1:0]    req_data,
  input  logic [1:0]      req_op,
  input  logic [SW-1:0]   req_src,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_long,
  input  logic            req_cach,
  input  logic            line_miss,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [SW-1:0]   rsp_src,
  output logic [1:0]      rsp_kind,
  output logic [W-1:0]    rsp_data,
  output logic            rsp_last,
  output logic            coh_valid,
  input  logic            coh_ready,
  output logic [SW-1:0]   coh_dst,
  output logic            coh_kind,
  output logic [AW-1:0]   coh_addr,
  output logic            coh_long,
  output logic [2*W-1:0]  coh_data,
  input  logic            coh_ack,
  output logic            xram_valid,
  input  logic            xram_ready,
  output logic [1:0]      xram_op,
  output logic [SW-1:0]   xram_src,
  output logic [AW-1:0]   xram_addr,
  output logic            xram_long,
  output logic [2*W-1:0]  xram_old,
  output logic [2*W-1:0]  xram_new
);
  state_e state_q, state_d;

  logic                        pkt_valid, pkt_take, pkt_long, pkt_cach;
  logic [1:0]                  pkt_op;
  logic [SW-1:0]               pkt_src;
  logic [AW-1:0]               pkt_addr;
  logic [MAX_FLITS-1:0][W-1:0] pkt_words;
  logic [2*W-1:0]              old_pair, new_pair;

  logic [W-1:0]    pa_lo, pa_hi, wd_data;
  logic [AW-1:0]   wd_addr;
  logic [NSRC-1:0] dir_mask;
  logic            wr_en, dir_set_en, dir_clr_en, match;

  logic            seq_start, seq_kind, seq_done;
  logic [NSRC-1:0] seq_mask;

  logic [1:0]      rsp_kind_q, rsp_kind_d;
  logic [W-1:0]    rsp_word_q, rsp_word_d;
  logic [AW-1:0]   rsp_ptr_q, rsp_ptr_d;
  logic [RW-1:0]   rsp_left_q, rsp_left_d;

  cas_pkt_collect #(.W(W), .AW(AW), .SW(SW)) i_collect (
    .clk(clk), .rst_n(rst_n), .accept_en(state_q == S_IDLE),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(req_data),
    .in_op(req_op), .in_src(req_src), .in_addr(req_addr),
    .in_long(req_long), .in_cach(req_cach),
    .pkt_valid(pkt_valid), .pkt_take(pkt_take), .pkt_op(pkt_op),
    .pkt_src(pkt_src), .pkt_addr(pkt_addr), .pkt_long(pkt_long),
    .pkt_cach(pkt_cach), .pkt_words(pkt_words)
  );

  always_comb begin
    old_pair = '0;
    new_pair = '0;
    case (pkt_op)
      OP_SC: begin
        if (pkt_long) begin
          old_pair = {pkt_words[1], pkt_words[0]};
          new_pair = {pkt_words[3], pkt_words[2]};
        end else begin
          old_pair = {{W{1'b0}}, pkt_words[0]};
          new_pair = {{W{1'b0}}, pkt_words[1]};
        end
      end
      OP_WRITE: new_pair = pkt_long ? {pkt_words[1], pkt_words[0]} : {{W{1'b0}}, pkt_words[0]};
      default: ;
    endcase
  end

  cas_store #(.W(W), .NWORDS(NWORDS), .LINE_WORDS(LINE_WORDS), .NSRC(NSRC)) i_store (
    .clk(clk), .rst_n(rst_n),
    .pa_addr(pkt_addr), .pa_long(pkt_long), .pa_lo(pa_lo), .pa_hi(pa_hi),
    .wd_addr(wd_addr), .wd_data(wd_data),
    .wr_en(wr_en), .wr_long(pkt_long), .wr_addr(pkt_addr),
    .wr_lo(new_pair[W-1:0]), .wr_hi(new_pair[2*W-1:W]),
    .dir_addr(pkt_addr), .dir_mask(dir_mask),
    .dir_set_en(dir_set_en), .dir_set_src(pkt_src), .dir_clr_en(dir_clr_en)
  );

  cas_coh_seq #(.W(W), .AW(AW), .NSRC(NSRC)) i_seq (
    .clk(clk), .rst_n(rst_n),
    .start(seq_start), .start_mask(seq_mask), .start_kind(seq_kind),
    .start_addr(pkt_addr), .start_long(pkt_long), .start_data(new_pair),
    .coh_valid(coh_valid), .coh_ready(coh_ready), .coh_dst(coh_dst),
    .coh_kind(coh_kind), .coh_addr(coh_addr), .coh_long(coh_long),
    .coh_data(coh_data), .coh_ack(coh_ack), .done(seq_done)
  );

  assign match = pkt_long ? (old_pair == {pa_hi, pa_lo}) : (old_pair[W-1:0] == pa_lo);

  always_comb begin
    state_d    = state_q;
    pkt_take   = 1'b0;
    wr_en      = 1'b0;
    dir_set_en = 1'b0;
    dir_clr_en = 1'b0;
    seq_start  = 1'b0;
    seq_mask   = '0;
    seq_kind   = CK_UPDATE;
    rsp_kind_d = rsp_kind_q;
    rsp_word_d = rsp_word_q;
    rsp_ptr_d  = rsp_ptr_q;
    rsp_left_d = rsp_left_q;
    case (state_q)
      S_IDLE: if (pkt_valid) begin
        pkt_take = 1'b1;
        if (line_miss) begin
          state_d = S_XRAM;
        end else begin
          case (pkt_op)
            OP_WRITE: begin
              wr_en      = 1'b1;
              seq_start  = 1'b1;
              seq_mask   = dir_mask & ~(NSRC'(1) << pkt_src);
              rsp_kind_d = RK_WACK;
              rsp_word_d = '0;
              rsp_left_d = RW'(1);
              state_d    = S_COH;
            end
            OP_SC: begin
              rsp_kind_d = RK_SC;
              rsp_left_d = RW'(1);
              if (match) begin
                wr_en      = 1'b1;
                seq_start  = 1'b1;
                seq_mask   = dir_mask;
                seq_kind   = INVAL_ON_SC ? CK_INVAL : CK_UPDATE;
                dir_clr_en = INVAL_ON_SC;
                rsp_word_d = W'(1);
                state_d    = S_COH;
              end else begin
                rsp_word_d = '0;
                state_d    = S_RSP;
              end
            end
            default: begin
              rsp_kind_d = RK_DATA;
              rsp_word_d = '0;
              if (pkt_cach) begin
                dir_set_en = 1'b1;
                rsp_ptr_d  = {pkt_addr[AW-1:LW], {LW{1'b0}}};
                rsp_left_d = RW'(LINE_WORDS);
              end else begin
                rsp_ptr_d  = pkt_addr;
                rsp_left_d = RW'(1);
              end
              state_d = S_RSP;
            end
          endcase
        end
      end
      S_COH: if (seq_done) state_d = S_RSP;
      S_RSP: if (rsp_ready) begin
        if (rsp_left_q == RW'(1)) begin
          state_d = S_IDLE;
        end else begin
          rsp_ptr_d  = rsp_ptr_q + AW'(1);
          rsp_left_d = rsp_left_q - RW'(1);
        end
      end
      S_XRAM: if (xram_ready) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      rsp_kind_q <= RK_DATA;
      rsp_word_q <= '0;
      rsp_ptr_q  <= '0;
      rsp_left_q <= '0;
    end else begin
      state_q    <= state_d;
      rsp_kind_q <= rsp_kind_d;
      rsp_word_q <= rsp_word_d;
      rsp_ptr_q  <= rsp_ptr_d;
      rsp_left_q <= rsp_left_d;
    end
  end

  assign wd_addr    = rsp_ptr_q;
  assign rsp_valid  = (state_q == S_RSP);
  assign rsp_src    = pkt_src;
  assign rsp_kind   = rsp_kind_q;
  assign rsp_data   = (rsp_kind_q == RK_DATA) ? wd_data : rsp_word_q;
  assign rsp_last   = (rsp_left_q == RW'(1));

  assign xram_valid = (state_q == S_XRAM);
  assign xram_op    = pkt_op;
  assign xram_src   = pkt_src;
  assign xram_addr  = pkt_addr;
  assign xram_long  = pkt_long;
  assign xram_old   = old_pair;
  assign xram_new   = new_pair;
endmodule

// File: rtl/cas_commit_unit_chk.sv
module cas_commit_unit_chk #(
  parameter int W  = 32,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [1:0]    rsp_kind,
  input logic [W-1:0]  rsp_data,
  input logic          coh_valid,
  input logic          coh_ready,
  input logic [SW-1:0] coh_dst,
  input logic          xram_valid,
  input logic          xram_ready
);
  p_busy_blocks_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || coh_valid || xram_valid) |-> !req_ready);

  p_one_stream_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, coh_valid, xram_valid}));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_kind)));

  p_coh_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (coh_valid && !coh_ready) |=> (coh_valid && $stable(coh_dst)));

  p_xram_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xram_valid && !xram_ready) |=> xram_valid);

  p_no_rsp_while_coh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (coh_valid && !coh_ready) |=> !rsp_valid);
endmodule

bind cas_commit_unit cas_commit_unit_chk #(.W(W), .SW(SW)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
  .coh_valid(coh_valid), .coh_ready(coh_ready), .coh_dst(coh_dst),
  .xram_valid(xram_valid), .xram_ready(xram_ready)
);

// File: tb/test_cas_commit_unit.sv
`timescale 1ns/100ps
module test_cas_commit_unit;
  localparam int W = 32, AW = 4, SW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_long = 0, req_cach = 0, line_miss = 0;
  logic [W-1:0] req_data = '0;
  logic [1:0] req_op = '0;
  logic [SW-1:0] req_src = '0;
  logic [AW-1:0] req_addr = '0;
  logic rsp_ready = 1, coh_ready = 1, coh_ack = 0, xram_ready = 0;
  logic req_ready, rsp_valid, rsp_last, coh_valid, coh_kind, coh_long, xram_valid, xram_long;
  logic [SW-1:0] rsp_src, coh_dst, xram_src;
  logic [1:0] rsp_kind, xram_op;
  logic [W-1:0] rsp_data;
  logic [AW-1:0] coh_addr, xram_addr;
  logic [2*W-1:0] coh_data, xram_old, xram_new;

  int vectors = 0, miscompares = 0;

  always #2.5 clk = ~clk;

  cas_commit_unit i_cas_commit_unit (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input int src, input int addr, input logic lng,
                      input logic cach, input int n, input logic [W-1:0] w [4]);
    req_op = op; req_src = SW'(src); req_addr = AW'(addr); req_long = lng; req_cach = cach;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_data = w[i]; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic get_rsp(input string req, output logic [1:0] k, output logic [W-1:0] d, output logic l);
    int t = 0;
    while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
    chk({req, " response arrives"}, 64'(rsp_valid), 64'd1);
    k = rsp_kind; d = rsp_data; l = rsp_last;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic collect_coh(input string req, input int n, output logic [3:0] mask,
                             output logic [2*W-1:0] data);
    int got = 0, t = 0;
    mask = '0; data = '0;
    while (got < n && t < 200) begin
      @(negedge clk); t++;
      if (coh_valid) begin
        mask[coh_dst] = 1'b1; data = coh_data; got++;
        chk({req, " coh kind update"}, 64'(coh_kind), 64'd0);
      end
    end
    repeat (2) @(negedge clk);
    chk({req, " no extra coh"}, 64'(coh_valid), 64'd0);
  endtask

  task automatic acks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); coh_ack = 1'b1;
      @(negedge clk); coh_ack = 1'b0;
      if (i < n - 1) begin
        @(negedge clk);
        chk("R5 held before last ack", 64'(rsp_valid), 64'd0);
      end
    end
  endtask

  task automatic read_word(input int addr, output logic [W-1:0] d);
    logic [W-1:0] w [4] = '{default: '0};
    logic [1:0] k; logic l;
    send(2'd0, 0, addr, 1'b0, 1'b0, 1, w);
    get_rsp("R7", k, d, l);
  endtask

  task automatic t_reset;
    logic [W-1:0] d;
    chk("R11 req_ready", 64'(req_ready), 64'd1);
    chk("R11 valids", 64'({rsp_valid, coh_valid, xram_valid}), 64'd0);
    read_word(5, d);
    chk("R11 zero word", 64'(d), 64'd0);
  endtask

  task automatic t_plain_write;
    logic [W-1:0] w [4] = '{32'h1111_AAAA, 0, 0, 0};
    logic [1:0] k; logic [W-1:0] d; logic l; logic [3:0] m; logic [2*W-1:0] cd;
    send(2'd1, 0, 5, 1'b0, 1'b0, 1, w);
    get_rsp("R6", k, d, l);
    chk("R6 write ack kind", 64'(k), 64'd1);
    collect_coh("R6", 0, m, cd);
    read_word(5, d);
    chk("R6 written", 64'(d), 64'h1111_AAAA);
  endtask

  task automatic t_cached_read;
    logic [W-1:0] w [4] = '{default: '0};
    logic [1:0] k; logic [W-1:0] d; logic l;
    logic [W-1:0] exp [4] = '{0, 32'h1111_AAAA, 0, 0};
    send(2'd0, 1, 6, 1'b0, 1'b1, 1, w);
    for (int i = 0; i < 4; i++) begin
      get_rsp("R7", k, d, l);
      chk("R7 line word", 64'(d), 64'(exp[i]));
      chk("R7 last flag", 64'(l), 64'(i == 3));
      chk("R7 data kind", 64'(k), 64'd0);
    end
    send(2'd0, 2, 4, 1'b0, 1'b1, 1, w);
    for (int i = 0; i < 4; i++) get_rsp("R7", k, d, l);
  endtask

  task automatic t_write_sharers;
    logic [W-1:0] w [4] = '{32'hBBBB_0006, 0, 0, 0};
    logic [1:0] k; logic [W-1:0] d; logic l; logic [3:0] m; logic [2*W-1:0] cd;
    send(2'd1, 1, 6, 1'b0, 1'b0, 1, w);
    collect_coh("R6", 1, m, cd);
    chk("R6 targets exclude source", 64'(m), 64'b0100);
    chk("R6 coh data", cd, 64'hBBBB_0006);
    chk("R5 no rsp before ack", 64'(rsp_valid), 64'd0);
    chk("R9 busy", 64'(req_ready), 64'd0);
    acks(1);
    get_rsp("R6", k, d, l);
    chk("R6 ack kind", 64'(k), 64'd1);
  endtask

  task automatic t_sc32;
    logic [W-1:0] bad [4] = '{32'hDEAD_0000, 32'hCCCC_0001, 0, 0};
    logic [W-1:0] good [4] = '{32'h1111_AAAA, 32'hCCCC_0001, 0, 0};
    logic [1:0] k; logic [W-1:0] d; logic l; logic [3:0] m; logic [2*W-1:0] cd;
    send(2'd2, 3, 5, 1'b0, 1'b0, 2, bad);
    get_rsp("R2", k, d, l);
    chk("R2 result false", 64'({k, d[0]}), 64'({2'd2, 1'b0}));
    collect_coh("R2", 0, m, cd);
    read_word(5, d);
    chk("R2 not written", 64'(d), 64'h1111_AAAA);
    send(2'd2, 3, 5, 1'b0, 1'b0, 2, good);
    collect_coh("R4", 2, m, cd);
    chk("R4 all sharers", 64'(m), 64'b0110);
    chk("R4 new value", cd, 64'hCCCC_0001);
    chk("R9 busy during acks", 64'(req_ready), 64'd0);
    acks(2);
    get_rsp("R1", k, d, l);
    chk("R1 result true", 64'({k, d}), 64'({2'd2, 32'd1}));
    read_word(5, d);
    chk("R1 written", 64'(d), 64'hCCCC_0001);
  endtask

  task automatic t_sc64;
    logic [W-1:0] wr [4] = '{32'h0000_1010, 32'h0000_2020, 0, 0};
    logic [W-1:0] hi_bad [4] = '{32'h0000_1010, 32'h0000_9999, 32'h0000_3030, 32'h0000_4040};
    logic [W-1:0] lo_bad [4] = '{32'h0000_9999, 32'h0000_2020, 32'h0000_3030, 32'h0000_4040};
    logic [W-1:0] ok [4] = '{32'h0000_1010, 32'h0000_2020, 32'h0000_3030, 32'h0000_4040};
    logic [1:0] k; logic [W-1:0] d; logic l;
    send(2'd1, 0, 8, 1'b1, 1'b0, 2, wr);
    get_rsp("R6", k, d, l);
    send(2'd2, 0, 9, 1'b1, 1'b0, 4, hi_bad);
    get_rsp("R3", k, d, l);
    chk("R3 high mismatch false", 64'(d), 64'd0);
    send(2'd2, 0, 8, 1'b1, 1'b0, 4, lo_bad);
    get_rsp("R3", k, d, l);
    chk("R3 low mismatch false", 64'(d), 64'd0);
    read_word(9, d);
    chk("R3 high kept", 64'(d), 64'h0000_2020);
    send(2'd2, 0, 8, 1'b1, 1'b0, 4, ok);
    get_rsp("R3", k, d, l);
    chk("R3 both match true", 64'(d), 64'd1);
    read_word(8, d);
    chk("R3 new low", 64'(d), 64'h0000_3030);
    read_word(9, d);
    chk("R3 new high", 64'(d), 64'h0000_4040);
  endtask

  task automatic t_miss;
    logic [W-1:0] w [4] = '{32'd5, 32'd7, 0, 0};
    logic [W-1:0] d;
    int t = 0;
    line_miss = 1'b1; xram_ready = 1'b0;
    send(2'd2, 2, 12, 1'b0, 1'b0, 2, w);
    while (!xram_valid && t < 50) begin @(negedge clk); t++; end
    chk("R8 record raised", 64'(xram_valid), 64'd1);
    repeat (3) @(negedge clk);
    chk("R10 xram held", 64'(xram_valid), 64'd1);
    chk("R8 record op/src/addr", 64'({xram_op, xram_src, xram_addr, xram_long}),
        64'({2'd2, 2'd2, 4'd12, 1'b0}));
    chk("R8 record old", xram_old, 64'd5);
    chk("R8 record new", xram_new, 64'd7);
    chk("R8 no response", 64'(rsp_valid), 64'd0);
    xram_ready = 1'b1;
    @(negedge clk);
    xram_ready = 1'b0; line_miss = 1'b0;
    chk("R9 ready after record", 64'(req_ready), 64'd1);
    read_word(12, d);
    chk("R8 nothing written", 64'(d), 64'd0);
  endtask

  task automatic t_backpressure;
    logic [W-1:0] w [4] = '{default: '0};
    logic [W-1:0] wr [4] = '{32'h0000_00F0, 0, 0, 0};
    logic [1:0] k; logic [W-1:0] d; logic l; logic [3:0] m; logic [2*W-1:0] cd;
    logic [W-1:0] d0;
    int t = 0;
    rsp_ready = 1'b0;
    send(2'd0, 3, 1, 1'b0, 1'b1, 1, w);
    while (!rsp_valid && t < 50) begin @(negedge clk); t++; end
    d0 = rsp_data;
    repeat (4) @(negedge clk);
    chk("R10 rsp held", 64'({rsp_valid, rsp_last, rsp_data}), 64'({1'b1, 1'b0, d0}));
    rsp_ready = 1'b1;
    get_rsp("R10", k, d, l);
    for (int i = 1; i < 4; i++) get_rsp("R7", k, d, l);
    chk("R7 last on final", 64'(l), 64'd1);
    send(2'd1, 0, 0, 1'b0, 1'b0, 1, wr);
    collect_coh("R6", 1, m, cd);
    chk("R7 reader registered", 64'(m), 64'b1000);
    acks(1);
    get_rsp("R6", k, d, l);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog R9 actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_write();
    t_cached_read();
    t_write_sharers();
    t_sc32();
    t_sc64();
    t_miss();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule